// File: doc/BRIEF.md
# Raised-Cosine Soft Mute

This block sits in a stereo sample path between a sample source and the rest of the audio chain. When the mute control is set, it fades both channels to silence along a stepped raised-cosine curve. When the control is cleared, it brings them back to full level along the same curve, stepped through in the opposite order. One gain value always scales left and right together, because the mute acts on the master channel only.

The curve is a table of `NUM_COEF` unsigned fixed-point gains, each with `COEF_W-1` fraction bits. Each gain is held for `HOLD_LEN` accepted samples. The table is worked out once from the parameters when the design is elaborated, so it needs no run-time arithmetic. The ramp position moves only when a sample strobe arrives, so every sample is scaled by exactly one gain. If the control changes while a ramp is under way, the ramp turns around at the sample it has reached and does not start again.

A two-bit status shows whether the path is fully open, ramping or fully silenced. Each scaled sample appears one clock after its strobe.

Top module: `soft_mute`

## Requirements
- R1: After reset `out_valid` is 0, both outputs are 0 and `mute_state` is 2'b00 (open).
- R2: When open with `mute` low, a strobed sample appears unchanged on its output one clock after `in_valid`, with `out_valid` high for that one clock.
- R3: Gain entry k equals round(2^(COEF_W-1) * (1 + cos(pi*k/(NUM_COEF-1))) / 2). Entry 0 is exactly unity and the last entry is exactly 0. The output is floor(sample * gain / 2^(COEF_W-1)).
- R4: With `mute` high, the n-th strobed sample counted from the open state (n from 0) uses gain entry floor(n/HOLD_LEN). The open state never becomes muted in a single step.
- R5: After NUM_COEF*HOLD_LEN strobes with `mute` high, `mute_state` is 2'b10 (muted), and every later sample strobed with `mute` high gives exactly 0.
- R6: With `mute` low after muting, the gain entries are used from the last back to entry 0, each for HOLD_LEN strobes. After NUM_COEF*HOLD_LEN strobes the state is open again. The first release strobe leaves the muted state.
- R7: Both channels are always scaled by the same gain, so equal inputs give equal outputs.
- R8: Without a strobe, the ramp position, the outputs and `mute_state` do not change, and `out_valid` is 0. The level of `mute` between strobes has no effect.
- R9: A change of `mute` part-way through a ramp reverses the ramp from its current position. A forward step never leaves the block open.
- R10: `mute_state` is 2'b01 (ramping) whenever the position is neither open nor muted. The value 2'b11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| mute | input | 1 | 1 asks for silence, 0 asks for full level |
| out_valid | output | 1 | Scaled sample strobe, one clock after `in_valid` |
| out_left | output | DATA_W | Left scaled sample, signed |
| out_right | output | DATA_W | Right scaled sample, signed |
| mute_state | output | 2 | 00 open, 01 ramping, 10 muted |

## Verification
The bench builds the block with its defaults: 24-bit samples, 32 gains of 16 bits, each held for 32 samples. A full fade therefore lasts 1024 strobes, and whole fades in both directions run in a few thousand clocks. The bench works out the gain table from the cosine in floating point, apart from the design's integer series. This brings into reach the full-scale products at both ends of the signed range, the exact unity and zero ends of the table, and reversals at positions that are not on a step boundary.

// File: rtl/mute_pkg.sv
package mute_pkg;
  typedef enum logic [1:0] {
    MS_OPEN  = 2'b00,
    MS_RAMP  = 2'b01,
    MS_MUTED = 2'b10
  } mute_state_e;
endpackage

// File: rtl/mute_coef_rom.sv
// Raised-cosine gain table, computed at elaboration from the parameters.
module mute_coef_rom #(
  parameter int NUM_COEF = 32,
  parameter int COEF_W   = 16
) (
  input  logic [$clog2(NUM_COEF)-1:0] idx,
  output logic [COEF_W-1:0]           coef
);
  localparam int FX = 30;
  localparam longint PI_FX = 64'sd3373259426;  // pi scaled by 2^30

  // cos(pi*k/(NUM_COEF-1)), scaled by 2^FX, folded onto [0, pi/2]
  function automatic longint cos_fx(int k);
    longint phi, phi2, term, sum;
    int span, kk;
    bit neg;
    span = NUM_COEF - 1;
    neg  = (2 * k > span);
    kk   = neg ? span - k : k;
    phi  = (PI_FX * longint'(kk)) / longint'(span);
    phi2 = (phi * phi) >>> FX;
    term = 64'sd1 <<< FX;
    sum  = term;
    for (int n = 1; n <= 12; n++) begin
      term = -((term * phi2) >>> FX) / longint'((2 * n - 1) * (2 * n));
      sum  = sum + term;
    end
    return neg ? -sum : sum;
  endfunction

  function automatic longint gain_at(int k);
    longint v;
    v = (((64'sd1 <<< FX) + cos_fx(k)) * (64'sd1 <<< (COEF_W - 1)) + (64'sd1 <<< FX)) >>> (FX + 1);
    if (v < 0) v = 0;
    if (v > (64'sd1 <<< (COEF_W - 1))) v = 64'sd1 <<< (COEF_W - 1);
    return v;
  endfunction

  function automatic logic [NUM_COEF*COEF_W-1:0] build_table();
    logic [NUM_COEF*COEF_W-1:0] t;
    t = '0;
    for (int k = 0; k < NUM_COEF; k++) t[k*COEF_W +: COEF_W] = COEF_W'(gain_at(k));
    return t;
  endfunction

  localparam logic [NUM_COEF*COEF_W-1:0] TABLE = build_table();

  assign coef = TABLE[idx*COEF_W +: COEF_W];
endmodule

// File: rtl/mute_ramp_ctrl.sv
// Ramp position: gain index, hold count within the index, and a muted flag.
module mute_ramp_ctrl
  import mute_pkg::*;
#(
  parameter int NUM_COEF = 32,
  parameter int HOLD_LEN = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  input  logic                        mute,
  output logic [$clog2(NUM_COEF)-1:0] coef_idx,
  output mute_state_e                 state,
  output logic                        fwd_step,
  output logic                        back_step
);
  localparam int IDX_W = $clog2(NUM_COEF);
  localparam int CNT_W = $clog2(HOLD_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_COEF - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_LEN - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             at_open;

  assign at_open   = !full_q && (idx_q == '0) && (cnt_q == '0);
  assign fwd_step  = step && mute && !full_q;
  assign back_step = step && !mute && !at_open;

  always_comb begin
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    if (fwd_step) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        if (idx_q == IDX_LAST) full_d = 1'b1;
        else                   idx_d  = idx_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (back_step) begin
      if (full_q) begin
        full_d = 1'b0;
        idx_d  = IDX_LAST;
        cnt_d  = CNT_LAST;
      end else if (cnt_q == '0) begin
        cnt_d = CNT_LAST;
        idx_d = idx_q - 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  // fading out uses the position before the step, fading in the one after
  assign coef_idx = mute ? idx_q : idx_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign state = full_q ? MS_MUTED : (at_open ? MS_OPEN : MS_RAMP);
endmodule

// File: rtl/mute_gain_mul.sv
// One channel: registered product of a signed sample and an unsigned gain.
module mute_gain_mul #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0]        coef,
  output logic signed [DATA_W-1:0] result
);
  localparam int PROD_W = DATA_W + COEF_W + 1;

  function automatic logic signed [DATA_W-1:0] scale(logic signed [DATA_W-1:0] s,
                                                     logic [COEF_W-1:0] g);
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    prod    = s * $signed({1'b0, g});
    shifted = prod >>> (COEF_W - 1);
    return shifted[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  result <= '0;
    else if (en) result <= scale(sample, coef);
  end
endmodule

// File: rtl/soft_mute.sv
module soft_mute
  import mute_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NUM_COEF = 32,
  parameter int HOLD_LEN = 32,
  parameter int COEF_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic                     mute,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic [1:0]               mute_state
);
  localparam int IDX_W = $clog2(NUM_COEF);
  localparam int NCH   = 2;

  logic [IDX_W-1:0]  coef_idx;
  logic [COEF_W-1:0] gain;
  mute_state_e       state;
  logic              fwd_step, back_step;

  mute_ramp_ctrl #(.NUM_COEF(NUM_COEF), .HOLD_LEN(HOLD_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .step(in_valid), .mute(mute),
    .coef_idx(coef_idx), .state(state),
    .fwd_step(fwd_step), .back_step(back_step)
  );

  mute_coef_rom #(.NUM_COEF(NUM_COEF), .COEF_W(COEF_W)) u_rom (
    .idx(coef_idx), .coef(gain)
  );

  logic signed [DATA_W-1:0] chan_in  [NCH];
  logic signed [DATA_W-1:0] chan_out [NCH];
  assign chan_in[0] = in_left;
  assign chan_in[1] = in_right;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    mute_gain_mul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .en(in_valid),
      .sample(chan_in[ch]), .coef(gain), .result(chan_out[ch])
    );
  end

  assign out_left  = chan_out[0];
  assign out_right = chan_out[1];

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign mute_state = state;
endmodule

// File: rtl/mute_checks.sv
module mute_checks
  import mute_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     mute,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic [1:0]               mute_state,
  input logic                     fwd_step,
  input logic                     back_step
);
  a_r8_valid_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right) && $stable(mute_state)));

  a_r2_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_state == MS_OPEN && !mute && in_valid) |=>
      (out_left == $past(in_left) && out_right == $past(in_right)));

  a_r5_muted_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_state == MS_MUTED && mute && in_valid) |=>
      (out_left == '0 && out_right == '0 && mute_state == MS_MUTED));

  a_r6_release_leaves_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_state == MS_MUTED && !mute && in_valid) |=> mute_state == MS_RAMP);

  a_r6_back_not_muted: assert property (@(posedge clk) disable iff (!rst_n)
    back_step |=> mute_state != MS_MUTED);

  a_r7_shared_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left == in_right) |=> out_left == out_right);

  a_r4_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    mute_state == MS_OPEN |=> mute_state != MS_MUTED);

  a_r9_fwd_leaves_open: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_step |=> mute_state != MS_OPEN);

  a_r10_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    mute_state != 2'b11);
endmodule

bind soft_mute mute_checks #(.DATA_W(DATA_W)) u_mute_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mute(mute),
  .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .mute_state(mute_state),
  .fwd_step(fwd_step), .back_step(back_step)
);

// File: tb/test_soft_mute.sv
`timescale 1ns/1ps
module test_soft_mute;
  localparam int DW   = 24;
  localparam int NC   = 32;
  localparam int HL   = 32;
  localparam int FULL = NC * HL;
  localparam int MAXP = (1 << (DW - 1)) - 1;
  localparam int MINN = -(1 << (DW - 1));

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic                 in_valid;
  logic signed [DW-1:0] in_left, in_right;
  logic                 mute;
  logic                 out_valid;
  logic signed [DW-1:0] out_left, out_right;
  logic [1:0]           mute_state;

  soft_mute #(.DATA_W(DW), .NUM_COEF(NC), .HOLD_LEN(HL), .COEF_W(16)) i_soft_mute (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .mute(mute), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .mute_state(mute_state)
  );

  int     checks = 0;
  int     errors = 0;
  int     pos    = 0;
  int     gtab[NC];
  bit     exp_v  = 1'b0;
  longint exp_l  = 0;
  longint exp_r  = 0;
  int     exp_s  = 0;
  string  tag    = "R1";

  function automatic int state_of(int p);
    return (p == 0) ? 0 : ((p == FULL) ? 2 : 1);
  endfunction

  function automatic int rnd_sample();
    return int'($urandom_range(32'((1 << DW) - 1))) + MINN;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_v || out_left !== DW'(exp_l) || out_right !== DW'(exp_r)
        || mute_state !== 2'(exp_s)) begin
      errors++;
      $display("FAIL %s: valid=%0b/%0b left=%0d/%0d right=%0d/%0d state=%0d/%0d (actual/expected)",
               tag, out_valid, exp_v, out_left, exp_l, out_right, exp_r, mute_state, exp_s);
    end
  endtask

  // compare results of the previous edge, then drive the next inputs and predict
  task automatic step(bit v, bit m, int l, int r);
    int k;
    @(negedge clk);
    compare();
    in_valid = v;
    mute     = m;
    in_left  = DW'(l);
    in_right = DW'(r);
    if (v) begin
      if (m) begin
        k = (pos >= FULL) ? NC - 1 : pos / HL;
        if (pos < FULL) pos++;
      end else begin
        if (pos > 0) pos--;
        k = pos / HL;
      end
      exp_l = (longint'(l) * longint'(gtab[k])) >>> 15;
      exp_r = (longint'(r) * longint'(gtab[k])) >>> 15;
      exp_v = 1'b1;
    end else begin
      exp_v = 1'b0;
    end
    exp_s = state_of(pos);
  endtask

  task automatic run(bit m, int n, int gap_every);
    for (int i = 0; i < n; i++) begin
      if (gap_every > 0 && (i % gap_every) == gap_every - 1)
        step(1'b0, ~m, rnd_sample(), rnd_sample());  // R8: mute level between strobes ignored
      step(1'b1, m, rnd_sample(), rnd_sample());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++)
      gtab[k] = $rtoi($floor(32768.0 * (1.0 + $cos(3.141592653589793 * real'(k) / real'(NC - 1))) / 2.0 + 0.5));
    rst_n = 1'b0; in_valid = 1'b0; mute = 1'b0; in_left = '0; in_right = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    step(1'b0, 1'b0, 0, 0);

    tag = "R2";
    step(1'b1, 1'b0, MAXP, MINN);
    step(1'b1, 1'b0, MINN, MAXP);
    run(1'b0, 40, 5);

    tag = "R3";  // full-scale samples through the whole fade show each gain entry
    for (int i = 0; i < FULL + 8; i++) step(1'b1, 1'b1, MAXP, MINN);

    tag = "R5";
    run(1'b1, 40, 6);

    tag = "R6";
    run(1'b0, FULL + 20, 7);

    tag = "R4";
    run(1'b1, 500, 9);

    tag = "R9";
    run(1'b0, 150, 0);
    run(1'b1, 70, 4);
    run(1'b0, 45, 0);
    run(1'b1, FULL, 0);
    run(1'b0, 13, 0);
    run(1'b0, FULL, 11);

    tag = "R7";
    for (int i = 0; i < 60; i++) begin
      int s;
      s = rnd_sample();
      step(1'b1, (i / 13) % 2 == 1, s, s);
    end

    tag = "R10";
    run(1'b1, 5, 0);
    run(1'b0, 8, 0);

    tag = "R8";
    for (int i = 0; i < 6; i++) step(1'b0, i[0], rnd_sample(), rnd_sample());
    step(1'b0, 1'b0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule